// File: doc/BRIEF.md
# Serial Test Pattern Generator

This block is the sending half of a bit error rate tester. It is placed in a serial transmit path between the normal data source and the line. While testing is switched on, the line carries a selectable test sequence in place of user data. The sequence can be one of three maximal-length pseudo-random sequences, a quasi-random signal sequence that limits runs of zeros, or a programmable word of 1 to 32 bits that repeats.

A gapped bit enable marks the bit times that belong to the tested channel. The sequence moves forward only in those bit times, so the pattern is spread across the payload slots and skips all other slots. Software-style control is reduced to a few strobes. A load strobe captures a new repeating word and its length, and also restarts the generator. A change of the selection restarts the generator in the same way. An error request inverts exactly one payload bit. When testing is switched off, the normal data passes straight through and the generator is frozen.

Top module: `bert_tx_gen`

## Requirements
- R1: Selection codes 0, 1 and 2 pick the pseudo-random sequences with polynomials x^9+x^5+1, x^15+x^14+1 and x^23+x^18+1. Each bit sent is b[n] = b[n-a] XOR b[n-b] for the polynomial x^a+x^b+1, taken over the bits generated before it.
- R2: Selection code 3 picks the quasi-random sequence. It is generated with x^20+x^17+1, and the output is delayed so that it is the generator bit from 14 bit times back. The output is forced to one whenever that bit and the 13 bits generated after it are all zero.
- R3: Any selection code with bit 2 set picks the repeating word. The word is sent from bit 0 upward and wraps after n bits. A captured length of 0 acts as 1, and a length above 32 acts as 32.
- R4: A pulse on the error request inverts exactly one payload bit. A request is held while no payload bit time occurs, or while testing is off, and is applied to the next payload bit and then dropped.
- R5: While testing is off, the serial output equals the normal data in every cycle. When testing is switched back on, the test pattern takes over the output again.
- R6: The sequence advances only in cycles where testing is on and the bit enable is high. In any other cycle the output pattern bit is held.
- R7: A load strobe, or a change of the selection code, restarts the generator from an all-ones history, or from bit 0 for the repeating word. The load strobe also captures the word and its length.
- R8: After reset, testing is off so the output follows the normal data. The selection is taken as code 0, the history is all ones, the word is zero with length 1, and no error is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Test pattern overrides normal data when high |
| bit_en | input | 1 | Gapped enable, high in payload bit times |
| pat_sel | input | 3 | Pattern selection code |
| load | input | 1 | Capture word and length, restart generator |
| rep_len | input | LEN_W (6) | Repeating word length n |
| rep_word | input | WORD_W (32) | Repeating word value |
| err_req | input | 1 | Request one inverted payload bit |
| norm_data | input | 1 | Normal serial transmit data |
| tx_data | output | 1 | Serial line output |

## Verification
The bench builds the block with its default 32-bit word and 6-bit length field. With those values, both clamp limits can be reached: a length of zero and a length of 40 beyond the top are loaded, next to the full 32-bit word and a single-bit word. A 23-bit history allows the longest polynomial and the 14-bit zero window of the quasi-random mode to be checked against a reference model of the recurrences. Gap masks such as alternating and sparse enables show that the sequence advances only in payload slots.

// File: rtl/bert_tx_pkg.sv
package bert_tx_pkg;

  // Shared history length: covers the longest polynomial (degree 23).
  localparam int unsigned HIST_W  = 23;
  localparam int unsigned TAP_W   = $clog2(HIST_W);
  // Zero-run window for the quasi-random mode.
  localparam int unsigned ZRUN_W  = 14;

  typedef enum logic [2:0] {
    SEL_PN9  = 3'd0,
    SEL_PN15 = 3'd1,
    SEL_PN23 = 3'd2,
    SEL_QRND = 3'd3,
    SEL_WORD = 3'd4
  } pat_sel_e;

  typedef struct packed {
    logic [TAP_W-1:0] far_tap;   // history index a-1
    logic [TAP_W-1:0] near_tap;  // history index b-1
    logic             qrnd;      // zero-run limiting output
  } tap_cfg_t;

  function automatic tap_cfg_t decode_taps(input logic [2:0] sel);
    tap_cfg_t cfg;
    cfg.qrnd = 1'b0;
    case (sel[1:0])
      2'd0: begin cfg.far_tap = TAP_W'(8);  cfg.near_tap = TAP_W'(4);  end
      2'd1: begin cfg.far_tap = TAP_W'(14); cfg.near_tap = TAP_W'(13); end
      2'd2: begin cfg.far_tap = TAP_W'(22); cfg.near_tap = TAP_W'(17); end
      default: begin
        cfg.far_tap  = TAP_W'(19);
        cfg.near_tap = TAP_W'(16);
        cfg.qrnd     = 1'b1;
      end
    endcase
    return cfg;
  endfunction

endpackage

// File: rtl/bert_lfsr_core.sv
module bert_lfsr_core
  import bert_tx_pkg::*;
#(
  parameter int unsigned W    = HIST_W,
  parameter int unsigned ZRUN = ZRUN_W,
  localparam int unsigned TW  = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reseed,
  input  logic          adv,
  input  logic [TW-1:0] far_tap,
  input  logic [TW-1:0] near_tap,
  input  logic          qrnd,
  output logic          pat_bit
);

  logic [W-1:0] hist_q;
  logic [W-1:0] hist_d;
  logic         fb;
  logic         zero_win;

  // New bit from the recurrence over earlier bits (index 0 = newest).
  always_comb begin
    fb       = hist_q[far_tap] ^ hist_q[near_tap];
    zero_win = (hist_q[ZRUN-1:0] == '0);
    pat_bit  = qrnd ? (hist_q[ZRUN-1] | zero_win) : fb;
  end

  always_comb begin
    hist_d = hist_q;
    if (reseed) begin
      hist_d = '1;
    end else if (adv) begin
      hist_d = {hist_q[W-2:0], fb};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '1;
    end else if (reseed || adv) begin
      hist_q <= hist_d;
    end
  end

  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!reseed && !adv) |=> $stable(hist_q)) else $error("lfsr moved without enable"); // R6

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hist_q != '0) else $error("lfsr history all zero"); // R7

  AST_LFSR_RESEED: assert property (@(posedge clk) disable iff (!rst_n)
    reseed |=> (hist_q == '1)) else $error("lfsr reseed value"); // R7

endmodule

// File: rtl/bert_word_gen.sv
module bert_word_gen #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LEN_W  = $clog2(WORD_W + 1),
  localparam int unsigned IDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              reseed,
  input  logic              adv,
  input  logic [LEN_W-1:0]  len_in,
  input  logic [WORD_W-1:0] word_in,
  output logic              pat_bit
);

  logic [WORD_W-1:0] word_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  len_clamped;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  idx_d;
  logic              at_last;

  always_comb begin
    if (len_in == '0) begin
      len_clamped = LEN_W'(1);
    end else if (len_in > LEN_W'(WORD_W)) begin
      len_clamped = LEN_W'(WORD_W);
    end else begin
      len_clamped = len_in;
    end
  end

  always_comb begin
    at_last = (LEN_W'(idx_q) == (len_q - LEN_W'(1)));
    pat_bit = word_q[idx_q];
    idx_d   = idx_q;
    if (reseed) begin
      idx_d = '0;
    end else if (adv) begin
      idx_d = at_last ? '0 : idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      len_q  <= LEN_W'(1);
    end else if (load) begin
      word_q <= word_in;
      len_q  <= len_clamped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (reseed || adv) begin
      idx_q <= idx_d;
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    LEN_W'(idx_q) < len_q) else $error("word index past length"); // R3

  AST_WORD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !reseed && at_last) |=> (idx_q == '0)) else $error("word did not wrap"); // R3

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != '0) && (len_q <= LEN_W'(WORD_W))) else $error("stored length illegal"); // R3

endmodule

// File: rtl/bert_err_inject.sv
module bert_err_inject (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic slot,
  output logic flip
);

  logic pend_q;
  logic pend_d;

  always_comb begin
    flip   = slot & (pend_q | req);
    pend_d = flip ? 1'b0 : (pend_q | req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && !req) |=> !pend_q) else $error("error stayed pending after use"); // R4

  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !slot) |=> pend_q) else $error("pending error lost"); // R4

endmodule

// File: rtl/bert_tx_gen.sv
module bert_tx_gen
  import bert_tx_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LEN_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_en,
  input  logic              bit_en,
  input  logic [2:0]        pat_sel,
  input  logic              load,
  input  logic [LEN_W-1:0]  rep_len,
  input  logic [WORD_W-1:0] rep_word,
  input  logic              err_req,
  input  logic              norm_data,
  output logic              tx_data
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_core_n;
  logic [2:0]             sel_q;
  logic                   reseed;
  logic                   slot;
  logic                   adv;
  logic                   word_mode;
  tap_cfg_t               taps;
  logic                   lfsr_bit;
  logic                   word_bit;
  logic                   pat_bit;
  logic                   flip;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      sel_q <= SEL_PN9;
    end else begin
      sel_q <= pat_sel;
    end
  end

  always_comb begin
    reseed    = load | (pat_sel != sel_q);
    slot      = test_en & bit_en;
    adv       = slot & ~reseed;
    word_mode = pat_sel[2];
    taps      = decode_taps(pat_sel);
  end

  bert_lfsr_core #(
    .W    (HIST_W),
    .ZRUN (ZRUN_W)
  ) i_lfsr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .reseed   (reseed),
    .adv      (adv & ~word_mode),
    .far_tap  (taps.far_tap),
    .near_tap (taps.near_tap),
    .qrnd     (taps.qrnd),
    .pat_bit  (lfsr_bit)
  );

  bert_word_gen #(
    .WORD_W (WORD_W),
    .LEN_W  (LEN_W)
  ) i_word (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load    (load),
    .reseed  (reseed),
    .adv     (adv & word_mode),
    .len_in  (rep_len),
    .word_in (rep_word),
    .pat_bit (word_bit)
  );

  bert_err_inject i_err (
    .clk   (clk),
    .rst_n (rst_core_n),
    .req   (err_req),
    .slot  (slot),
    .flip  (flip)
  );

  always_comb begin
    pat_bit = word_mode ? word_bit : lfsr_bit;
    tx_data = test_en ? (pat_bit ^ flip) : norm_data;
  end

  AST_NO_FLIP_IDLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    !test_en |-> !flip) else $error("error applied while off"); // R4

endmodule

// File: tb/test_bert_tx_gen.sv
module test_bert_tx_gen;

  localparam int WORD_W = 32;
  localparam int LEN_W  = 6;
  localparam int NCYC   = 200;

  // {sel[2:0], len[5:0], word[31:0], gap[15:0], err_at[7:0]}
  localparam logic [64:0] VEC [8] = '{
    {3'd0, 6'd0,  32'h0000_0000, 16'hffff, 8'hff},
    {3'd1, 6'd0,  32'h0000_0000, 16'h5555, 8'hff},
    {3'd2, 6'd0,  32'h0000_0000, 16'hffff, 8'd10},
    {3'd3, 6'd0,  32'h0000_0000, 16'hffff, 8'hff},
    {3'd4, 6'd1,  32'h0000_0001, 16'hffff, 8'hff},
    {3'd5, 6'd32, 32'hdead_beef, 16'hf0f3, 8'd37},
    {3'd6, 6'd40, 32'h8000_0001, 16'h0101, 8'hff},
    {3'd7, 6'd0,  32'h0000_0002, 16'hffff, 8'hff}
  };

  logic              clk;
  logic              rst_n;
  logic              test_en;
  logic              bit_en;
  logic [2:0]        pat_sel;
  logic              load;
  logic [LEN_W-1:0]  rep_len;
  logic [WORD_W-1:0] rep_word;
  logic              err_req;
  logic              norm_data;
  logic              tx_data;

  int n_chk;
  int n_bad;

  // Reference model state
  logic [31:0] h;
  logic [31:0] m_word;
  int          m_len;
  int          m_idx;
  logic        m_pend;
  logic [2:0]  m_sel;

  bert_tx_gen i_bert_tx_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_en   (test_en),
    .bit_en    (bit_en),
    .pat_sel   (pat_sel),
    .load      (load),
    .rep_len   (rep_len),
    .rep_word  (rep_word),
    .err_req   (err_req),
    .norm_data (norm_data),
    .tx_data   (tx_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: tx_data=%b expected %b", req, got, exp);
    end
  endtask

  function automatic logic model_fb();
    case (m_sel[1:0])
      2'd0:    return h[8] ^ h[4];
      2'd1:    return h[14] ^ h[13];
      2'd2:    return h[22] ^ h[17];
      default: return h[19] ^ h[16];
    endcase
  endfunction

  function automatic logic model_bit();
    if (m_sel[2]) return m_word[m_idx];
    if (m_sel == 3'd3) return h[13] | (h[13:0] == 14'd0);
    return model_fb();
  endfunction

  task automatic step(input logic te, input logic be, input logic er,
                      input logic nd, input logic ld, input string req);
    logic rs;
    logic sl;
    logic ap;
    logic ex;
    @(negedge clk);
    test_en = te; bit_en = be; err_req = er; norm_data = nd; load = ld;
    #1;
    rs = ld || (pat_sel != m_sel);
    if (rs) begin
      h = '1; m_idx = 0; m_sel = pat_sel;
      if (ld) begin
        m_len  = (rep_len == 0) ? 1 : (rep_len > 32) ? 32 : int'(rep_len);
        m_word = rep_word;
      end
    end else begin
      sl = te && be;
      ap = sl && (m_pend || er);
      ex = te ? (model_bit() ^ ap) : nd;
      check(tx_data, ex, req);
      m_pend = ap ? 1'b0 : (m_pend | er);
      if (sl) begin
        if (m_sel[2]) m_idx = (m_idx == m_len - 1) ? 0 : m_idx + 1;
        else h = {h[30:0], model_fb()};
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    h = '1; m_word = '0; m_len = 1; m_idx = 0; m_pend = 1'b0; m_sel = 3'd0;
    rst_n = 1'b0; test_en = 1'b0; bit_en = 1'b0; pat_sel = 3'd0; load = 1'b0;
    rep_len = '0; rep_word = '0; err_req = 1'b0; norm_data = 1'b0;

    // R8: output follows normal data in reset and just after it
    #35;
    norm_data = 1'b1; #1; check(tx_data, 1'b1, "R8");
    norm_data = 1'b0; #1; check(tx_data, 1'b0, "R8");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    // R8: seeded PN9 after reset, no load needed
    repeat (20) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R8");

    // Table walk: R1 R2 R3 plus R4 R6 through gaps and error pulses
    for (int v = 0; v < 8; v++) begin
      logic [64:0] e;
      logic [15:0] gap;
      logic [7:0]  err_at;
      string       tag;
      e        = VEC[v];
      pat_sel  = e[64:62];
      rep_len  = e[61:56];
      rep_word = e[55:24];
      gap      = e[23:8];
      err_at   = e[7:0];
      tag = pat_sel[2] ? "R3" : (pat_sel == 3'd3) ? "R2" : "R1";
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
      for (int c = 0; c < NCYC; c++) begin
        step(1'b1, gap[c % 16], (c == int'(err_at)), 1'b0, 1'b0, tag);
      end
    end

    // R5 and R6: bypass while off, no advance, pattern resumes
    pat_sel = 3'd0;
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    repeat (5) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
    for (int k = 0; k < 10; k++) step(1'b0, 1'b1, 1'b0, k[0], 1'b0, "R5");
    repeat (4) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
    repeat (10) step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R6");

    // R4: request held across idle bit times, applied once
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
    repeat (3) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    repeat (4) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
    // R4: request made while testing is off is kept for later
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R4");
    repeat (4) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
    // R4: request on a payload bit applies at once
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
    repeat (3) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4");

    // R7: selection change without load restarts the generator
    pat_sel = 3'd1;
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    repeat (40) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    pat_sel = 3'd4;
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    repeat (40) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    pat_sel = 3'd3;
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    repeat (40) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2");

    // R5: handing the path back to normal data
    for (int k = 0; k < 6; k++) step(1'b0, 1'b0, 1'b0, ~k[1], 1'b0, "R5");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule